// File: doc/BRIEF.md
# Framed Serial Output Latch

This block is the receive side of a serial output-control port. A host frames a transfer with an active-low select, clocks data in on a serial clock, most significant bit first, and the block holds the result in a parallel latch of output-enable bits. A bit at 1 switches its channel on, and a bit at 0 switches it off. The latch changes only when the select returns high after a whole number of bytes has been clocked in. Any other frame length is treated as corrupt and is dropped.

The serial output always presents the oldest bit of the shift register. Several blocks that share select and clock can therefore be chained data-out to data-in, and one long frame loads all of them at once. An active-low disable input clears the outputs at once, without waiting for a clock edge. The outputs then stay off until a later valid frame is committed.

All serial inputs are oversampled by the system clock through synchronizers, and edges are found in that clock domain. The serial output comes as a data bit plus an enable, ready for a tri-state pad.

Top module: `framed_out_latch`

## Requirements
- R1: `chan_o` changes only on a valid commit or under disable; at any other time it keeps its value.
- R2: A frame of exactly 8 serial clock rising edges, ended by the rising edge of `cs_ni`, loads `chan_o` a few system clocks after `cs_ni` rises. The first bit received goes to `chan_o[7]` and the last to `chan_o[0]`, and a 1 turns the channel on.
- R3: A frame whose count of rising edges is zero or not a multiple of 8 (for example 7 or 9) is dropped, and `chan_o` keeps its previous value.
- R4: A frame of 16 rising edges commits the last 8 bits received.
- R5: On each falling edge of the serial clock, `so_o` shows the current register MSB. Two blocks chained `so_o` to `si_i` and sharing select and clock end a 16-bit frame with the first 8 bits in the downstream block and the last 8 in the upstream one.
- R6: While `cs_ni` is high, `so_oe_o` is 0, and edges on `sclk_i` and `si_i` leave the shift register unchanged.
- R7: After `cs_ni` falls, `so_oe_o` is 1 and `so_o` shows the register MSB before any serial clock edge.
- R8: While `dis_ni` is low, `chan_o` is 0 asynchronously. A frame during which `dis_ni` was low is dropped, so `chan_o` stays 0 after `dis_ni` returns high.
- R9: After `dis_ni` returns high, the next valid frame sets `chan_o` again.
- R10: When `dis_ni` falls at the same moment as a valid frame's closing select edge, the disable wins and `chan_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| si_i | input | 1 | Serial data in, MSB first |
| dis_ni | input | 1 | Asynchronous active-low output disable |
| so_o | output | 1 | Serial data out, the oldest bit of the shift register |
| so_oe_o | output | 1 | Enable for the serial output pad, high while selected |
| chan_o | output | 8 | Latched output-enable bits, 1 = on |

## Verification
A frame commit and a disable can land in the same system clock cycle. The commit is decoded from the synchronized rising edge of the select. The disable clears the latch through its asynchronous path. The bench closes a valid 8-bit frame by driving `cs_ni` high and `dis_ni` low on the same edge. It releases the disable only after the commit window has passed and then expects `chan_o` to read 0. A separate case drops the disable in the middle of a frame, finishes the frame, and checks that the frame was dropped.

// File: rtl/fol_pkg.sv
package fol_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t find_edge(input logic prev, input logic cur);
    edge_t e;
    e.rise = !prev && cur;
    e.fall = prev && !cur;
    return e;
  endfunction
endpackage

// File: rtl/fol_sync.sv
module fol_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fol_shifter.sv
module fol_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_act_i,
  input  logic         cs_fall_i,
  input  logic         cs_rise_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         si_i,
  input  logic         dis_n_i,
  output logic         commit_o,
  output logic [W-1:0] data_o,
  output logic         so_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          nz_q;
  logic          abort_q;
  logic          so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      nz_q    <= 1'b0;
      abort_q <= 1'b0;
      so_q    <= 1'b0;
    end else if (cs_fall_i) begin
      cnt_q   <= '0;
      nz_q    <= 1'b0;
      abort_q <= !dis_n_i;
      so_q    <= sr_q[W-1];
    end else if (cs_act_i) begin
      if (sclk_rise_i) begin
        sr_q  <= {sr_q[W-2:0], si_i};
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        nz_q  <= 1'b1;
      end
      if (sclk_fall_i) so_q <= sr_q[W-1];
      if (!dis_n_i) abort_q <= 1'b1;
    end
  end

  // whole bytes, at least one, no disable seen in the frame
  assign commit_o = cs_rise_i && (cnt_q == '0) && nz_q && !abort_q && dis_n_i;
  assign data_o   = sr_q;
  assign so_o     = so_q;

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> $stable(sr_q));

  a_r7_so_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> so_q == $past(sr_q[W-1]));

  a_r5_so_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && sclk_fall_i && !cs_fall_i) |=> so_q == $past(sr_q[W-1]));
endmodule

// File: rtl/fol_latch.sv
module fol_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dis_ni,
  input  logic         commit_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni or negedge dis_ni) begin
    if (!rst_ni)       latch_q <= '0;
    else if (!dis_ni)  latch_q <= '0;
    else if (commit_i) latch_q <= data_i;
  end

  assign q_o = latch_q;

  a_r8_dis_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_ni |-> latch_q == '0);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !dis_ni)
    !commit_i |=> $stable(latch_q));
endmodule

// File: rtl/framed_out_latch.sv
module framed_out_latch #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             si_i,
  input  logic             dis_ni,
  output logic             so_o,
  output logic             so_oe_o,
  output logic [WIDTH-1:0] chan_o
);
  import fol_pkg::*;

  localparam int unsigned NSYNC = 4;
  // bit order: {dis, si, sclk, cs}
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1011;

  logic [NSYNC-1:0] raw, synced;
  logic             cs_prev_q, sclk_prev_q;
  edge_t            cs_e, sclk_e;
  logic             commit;
  logic [WIDTH-1:0] sr_data;

  assign raw = {dis_ni, si_i, sclk_i, cs_ni};

  fol_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b1;
    end else begin
      cs_prev_q   <= synced[0];
      sclk_prev_q <= synced[1];
    end
  end

  assign cs_e   = find_edge(cs_prev_q, synced[0]);
  assign sclk_e = find_edge(sclk_prev_q, synced[1]);

  fol_shifter #(.W(WIDTH)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (!synced[0]),
    .cs_fall_i  (cs_e.fall),
    .cs_rise_i  (cs_e.rise),
    .sclk_rise_i(sclk_e.rise),
    .sclk_fall_i(sclk_e.fall),
    .si_i       (synced[2]),
    .dis_n_i    (synced[3]),
    .commit_o   (commit),
    .data_o     (sr_data),
    .so_o       (so_o)
  );

  fol_latch #(.W(WIDTH)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dis_ni  (dis_ni),
    .commit_i(commit),
    .data_i  (sr_data),
    .q_o     (chan_o)
  );

  assign so_oe_o = !synced[0];

  a_r2_commit_load: assert property (@(posedge clk_i) disable iff (!rst_ni || !dis_ni)
    commit |=> chan_o == $past(sr_data));

  a_r6_no_commit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !cs_prev_q == 1'b1);
endmodule

// File: tb/framed_out_latch_tb.sv
module framed_out_latch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, si = 1'b0, dis_n = 1'b1;
  logic so_a, oe_a, so_b, oe_b;
  logic [7:0] chan_a, chan_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  framed_out_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .si_i(si),
    .dis_ni(dis_n), .so_o(so_a), .so_oe_o(oe_a), .chan_o(chan_a)
  );

  framed_out_latch u_chain (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .si_i(so_a),
    .dis_ni(dis_n), .so_o(so_b), .so_oe_o(oe_b), .chan_o(chan_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open();
    @(negedge clk); cs_n = 1'b0; wait_n(8);
  endtask

  task automatic cs_close();
    wait_n(4); cs_n = 1'b1; wait_n(12);
  endtask

  task automatic shift_bit(input logic b);
    si = b; sclk = 1'b0; wait_n(8);
    sclk = 1'b1; wait_n(8);
  endtask

  task automatic frame(input int n, input logic [31:0] bits);
    cs_open();
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
    cs_close();
  endtask

  task automatic t_reset();
    chk("R1 reset chan", chan_a, 8'h00);
    chk("R6 reset so_oe", oe_a, 1'b0);
  endtask

  task automatic t_byte();
    frame(8, 32'hA5);
    chk("R2 8-clock frame", chan_a, 8'hA5);
    frame(8, 32'h01);
    chk("R2 first bit lands in chan[7]", chan_a, 8'h01);
    wait_n(20);
    chk("R1 hold without frame", chan_a, 8'h01);
  endtask

  task automatic t_bad_len();
    frame(7, 32'h7F);
    chk("R3 7 clocks dropped", chan_a, 8'h01);
    frame(9, 32'h1FF);
    chk("R3 9 clocks dropped", chan_a, 8'h01);
    frame(0, 32'h0);
    chk("R3 zero clocks dropped", chan_a, 8'h01);
  endtask

  task automatic t_long_chain();
    frame(16, 32'h3C5A);
    chk("R4 16 clocks commit last byte", chan_a, 8'h5A);
    chk("R5 chained block gets first byte", chan_b, 8'h3C);
  endtask

  task automatic t_idle_ignore();
    frame(8, 32'h80);
    chk("R2 frame 0x80", chan_a, 8'h80);
    for (int i = 0; i < 6; i++) begin
      si = 1'b0; sclk = 1'b0; wait_n(8);
      chk("R6 so_oe low while deselected", oe_a, 1'b0);
      sclk = 1'b1; wait_n(8);
    end
    chk("R6 chan unchanged while deselected", chan_a, 8'h80);
    @(negedge clk); cs_n = 1'b0; wait_n(6);
    chk("R6 register untouched (msb still 1)", so_a, 1'b1);
    chk("R7 so_oe high after select", oe_a, 1'b1);
    cs_close();
    chk("R3 select with no clocks leaves chan", chan_a, 8'h80);
  endtask

  task automatic t_so_select();
    frame(8, 32'h3C);
    @(negedge clk); cs_n = 1'b0; wait_n(6);
    chk("R7 so shows msb 0 at select", so_a, 1'b0);
    shift_bit(1'b1);
    chk("R5 so shows next bit after fall", so_a, 1'b0);
    wait_n(2);
    cs_n = 1'b1; wait_n(6);
    chk("R6 so_oe drops on deselect", oe_a, 1'b0);
    chk("R3 1-clock frame dropped", chan_a, 8'h3C);
  endtask

  task automatic t_dis_mid();
    cs_open();
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        dis_n = 1'b0; #1;
        chk("R8 chan cleared at once by disable", chan_a, 8'h00);
        wait_n(10);
        dis_n = 1'b1; wait_n(4);
      end
      shift_bit(1'b1);
    end
    cs_close();
    chk("R8 frame spanning disable dropped", chan_a, 8'h00);
    frame(8, 32'h81);
    chk("R9 new frame after disable", chan_a, 8'h81);
  endtask

  task automatic t_dis_commit();
    cs_open();
    for (int i = 7; i >= 0; i--) shift_bit(i[0]);
    wait_n(4);
    cs_n = 1'b1; dis_n = 1'b0;
    wait_n(20);
    dis_n = 1'b1; wait_n(10);
    chk("R10 disable wins over commit", chan_a, 8'h00);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_byte();
    t_bad_len();
    t_long_chain();
    t_idle_ignore();
    t_so_select();
    t_dis_mid();
    t_dis_commit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule